// File: doc/BRIEF.md
# Frame Rate Band Detector

This block watches a left/right frame clock and measures how many cycles of a fixed reference clock fit into one frame. It then sorts the frame rate into one of three oversampling speed bands: single (30 kHz to 54 kHz), double (60 kHz to 108 kHz) and quad (120 kHz to 216 kHz). Rates in the gaps between these bands, or outside them, are flagged as unsupported. A downstream filter or clock generator uses the reported band.

A new band is reported only after the same classification has been seen over several consecutive frames, so one bad frame cannot move the output. A two-bit mode select either leaves detection running (value zero, the reset default) or forces one of the three bands. A watchdog on the frame clock drops the valid flag when frames stop arriving.

Top module: `rate_band_detect`

## Requirements
- R1: After reset `speed_mode` is 0 (single), `mode_valid` is 0 and `out_of_range` is 0.
- R2: The measured period is the number of reference cycles between two consecutive rising edges of `lrck`. The first rising edge after reset or after a timeout only starts a measurement and is not classified.
- R3: A period from REF_HZ/54000 to REF_HZ/30000 cycles, both ends included, is classified as single speed, reported as `speed_mode` = 0.
- R4: A period from REF_HZ/108000 to REF_HZ/60000 cycles is classified as double speed, reported as `speed_mode` = 1.
- R5: A period from REF_HZ/216000 to REF_HZ/120000 cycles is classified as quad speed, reported as `speed_mode` = 2.
- R6: When the confirmed classification lies in no band, `out_of_range` goes to 1, `mode_valid` goes to 0 and `speed_mode` keeps its last in-band value. `mode_valid` and `out_of_range` are never 1 together.
- R7: In automatic mode the outputs change only after DEBOUNCE (default 4) consecutive measured periods have the same classification. A differing period restarts the count.
- R8: With `fm_sel` = 1, 2 or 3, `speed_mode` becomes `fm_sel` − 1 with `mode_valid` = 1 and `out_of_range` = 0 on the next clock. This holds whatever `lrck` does, including when it stops.
- R9: When `fm_sel` returns to 0, `mode_valid` and `out_of_range` clear on the next clock. `speed_mode` is held until DEBOUNCE new matching periods are seen.
- R10: In automatic mode, if no rising `lrck` edge arrives within TIMEOUT_CYC reference cycles, `mode_valid` clears and `speed_mode` is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; all counting is in these cycles |
| rst | input | 1 | Synchronous active-high reset |
| lrck | input | 1 | Frame clock, asynchronous to `clk` |
| fm_sel | input | 2 | 0 = automatic, 1/2/3 = force single/double/quad |
| speed_mode | output | 2 | Reported band: 0 single, 1 double, 2 quad |
| mode_valid | output | 1 | Reported band is confirmed and current |
| out_of_range | output | 1 | Confirmed frame rate lies in no band |

## Verification
A sweep steps the frame period one cycle at a time across the whole range of a small reference configuration. This covers the gaps below quad, between the bands and above single, so every band edge is checked for both inclusion and exclusion. Sequences that change the period separate the debounce count from a premature switch, and an interrupted run shows that the count restarts. Forced modes are applied with the frame clock running and with it stopped, which tells forcing apart from detection. A silent frame clock separates the timeout from holding the mode.

// File: rtl/rate_band_pkg.sv
package rate_band_pkg;
  typedef enum logic [1:0] {
    SPD_SINGLE = 2'd0,
    SPD_DOUBLE = 2'd1,
    SPD_QUAD   = 2'd2
  } speed_e;

  localparam int NUM_BANDS = 3;
endpackage

// File: rtl/lrck_edge.sv
module lrck_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic lrck_in,
  output logic rise
);
  // chain[0..STAGES-1] synchronise, chain[STAGES] holds the previous level
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-1:0], lrck_in};
  end

  assign rise = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/period_meter.sv
module period_meter #(
  parameter int TIMEOUT_CYC = 2048,
  localparam int CW = $clog2(TIMEOUT_CYC + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rise,
  output logic          meas_stb,
  output logic [CW-1:0] meas_len,
  output logic          timed_out
);
  localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT_CYC);

  logic [CW-1:0] cnt;
  logic          armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      armed     <= 1'b0;
      meas_stb  <= 1'b0;
      meas_len  <= '0;
      timed_out <= 1'b0;
    end else begin
      meas_stb  <= 1'b0;
      timed_out <= 1'b0;
      if (rise) begin
        cnt   <= CW'(1);
        armed <= 1'b1;
        if (armed) begin
          meas_stb <= 1'b1;
          meas_len <= cnt;
        end
      end else if (cnt == LIMIT - CW'(1)) begin
        cnt       <= LIMIT;
        armed     <= 1'b0;
        timed_out <= 1'b1;
      end else if (cnt != LIMIT) begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  p_len_bound_r2: assert property (@(posedge clk) disable iff (rst)
    meas_stb |-> (meas_len != '0 && meas_len < LIMIT));

  p_timeout_disarm_r10: assert property (@(posedge clk) disable iff (rst)
    timed_out |=> !meas_stb);
endmodule

// File: rtl/band_classify.sv
module band_classify
  import rate_band_pkg::*;
#(
  parameter int REF_HZ = 24_576_000,
  parameter int CW     = 12
) (
  input  logic [CW-1:0] meas_len,
  output logic          in_band,
  output speed_e        band
);
  // band b: lowest and highest rate in Hz; fewer cycles means a faster rate
  localparam int RATE_MIN [NUM_BANDS] = '{30_000, 60_000, 120_000};
  localparam int RATE_MAX [NUM_BANDS] = '{54_000, 108_000, 216_000};

  logic [NUM_BANDS-1:0] hit;

  for (genvar b = 0; b < NUM_BANDS; b++) begin : g_band
    localparam logic [CW-1:0] LO = CW'(REF_HZ / RATE_MAX[b]);
    localparam logic [CW-1:0] HI = CW'(REF_HZ / RATE_MIN[b]);
    assign hit[b] = (meas_len >= LO) && (meas_len <= HI);
  end

  always_comb begin
    in_band = |hit;
    band    = SPD_SINGLE;
    if (hit[1]) band = SPD_DOUBLE;
    if (hit[2]) band = SPD_QUAD;
  end
endmodule

// File: rtl/mode_filter.sv
module mode_filter
  import rate_band_pkg::*;
#(
  parameter int DEBOUNCE = 4,
  localparam int SW = $clog2(DEBOUNCE + 1)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       meas_stb,
  input  logic       in_band,
  input  speed_e     band,
  input  logic       timed_out,
  input  logic [1:0] fm_sel,
  output speed_e     speed_mode,
  output logic       mode_valid,
  output logic       out_of_range
);
  localparam logic [SW-1:0] TARGET = SW'(DEBOUNCE);

  logic          manual, manual_q;
  logic [2:0]    cand, new_cls;
  logic [SW-1:0] streak, next_streak;

  assign manual  = (fm_sel != 2'd0);
  // out-of-band periods share one candidate code regardless of length
  assign new_cls = in_band ? {1'b1, band} : 3'b000;

  always_comb begin
    if (streak != '0 && new_cls == cand)
      next_streak = (streak == TARGET) ? streak : streak + SW'(1);
    else
      next_streak = SW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      speed_mode   <= SPD_SINGLE;
      mode_valid   <= 1'b0;
      out_of_range <= 1'b0;
      cand         <= 3'b000;
      streak       <= '0;
      manual_q     <= 1'b0;
    end else begin
      manual_q <= manual;
      if (meas_stb) begin
        cand   <= new_cls;
        streak <= next_streak;
      end
      if (timed_out) streak <= '0;

      if (manual) begin
        speed_mode   <= speed_e'(fm_sel - 2'd1);
        mode_valid   <= 1'b1;
        out_of_range <= 1'b0;
      end else if (manual_q) begin
        mode_valid   <= 1'b0;
        out_of_range <= 1'b0;
        streak       <= '0;
      end else if (timed_out) begin
        mode_valid <= 1'b0;
      end else if (meas_stb && next_streak == TARGET) begin
        if (in_band) begin
          speed_mode   <= band;
          mode_valid   <= 1'b1;
          out_of_range <= 1'b0;
        end else begin
          mode_valid   <= 1'b0;
          out_of_range <= 1'b1;
        end
      end
    end
  end

  p_flags_exclusive_r6: assert property (@(posedge clk) disable iff (rst)
    !(mode_valid && out_of_range));

  p_oor_holds_mode_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(out_of_range) |-> $stable(speed_mode));

  p_manual_forces_r8: assert property (@(posedge clk) disable iff (rst)
    (fm_sel != 2'd0) |=> (mode_valid && !out_of_range &&
                          speed_mode == speed_e'($past(fm_sel) - 2'd1)));

  p_change_needs_period_r7: assert property (@(posedge clk) disable iff (rst)
    (speed_mode != $past(speed_mode) && !$past(manual)) |-> $past(meas_stb));

  p_legal_code_r3: assert property (@(posedge clk) disable iff (rst)
    speed_mode != 2'd3);
endmodule

// File: rtl/rate_band_detect.sv
module rate_band_detect
  import rate_band_pkg::*;
#(
  parameter int REF_HZ      = 24_576_000,
  parameter int TIMEOUT_CYC = 2048,
  parameter int DEBOUNCE    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       lrck,
  input  logic [1:0] fm_sel,
  output logic [1:0] speed_mode,
  output logic       mode_valid,
  output logic       out_of_range
);
  localparam int CW = $clog2(TIMEOUT_CYC + 1);

  logic          rise, meas_stb, timed_out, in_band;
  logic [CW-1:0] meas_len;
  speed_e        band, mode_q;

  lrck_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst(rst), .lrck_in(lrck), .rise(rise)
  );

  period_meter #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_meter (
    .clk(clk), .rst(rst), .rise(rise),
    .meas_stb(meas_stb), .meas_len(meas_len), .timed_out(timed_out)
  );

  band_classify #(.REF_HZ(REF_HZ), .CW(CW)) u_class (
    .meas_len(meas_len), .in_band(in_band), .band(band)
  );

  mode_filter #(.DEBOUNCE(DEBOUNCE)) u_filter (
    .clk(clk), .rst(rst), .meas_stb(meas_stb), .in_band(in_band),
    .band(band), .timed_out(timed_out), .fm_sel(fm_sel),
    .speed_mode(mode_q), .mode_valid(mode_valid), .out_of_range(out_of_range)
  );

  assign speed_mode = mode_q;
endmodule

// File: tb/rate_band_detect_tb.sv
module rate_band_detect_tb;
  localparam int REF_HZ  = 2_160_000;
  localparam int TIMEOUT = 200;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       lrck = 1'b0;
  logic [1:0] fm_sel = 2'd0;
  logic [1:0] speed_mode;
  logic       mode_valid, out_of_range;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  rate_band_detect #(.REF_HZ(REF_HZ), .TIMEOUT_CYC(TIMEOUT), .DEBOUNCE(4)) u_dut (
    .clk(clk), .rst(rst), .lrck(lrck), .fm_sel(fm_sel),
    .speed_mode(speed_mode), .mode_valid(mode_valid), .out_of_range(out_of_range)
  );

  task automatic check(string req, logic [1:0] m, logic v, logic o);
    checks++;
    if (speed_mode !== m || mode_valid !== v || out_of_range !== o) begin
      errors++;
      $display("FAIL %s: got mode=%0d valid=%0b oor=%0b expected mode=%0d valid=%0b oor=%0b",
               req, speed_mode, mode_valid, out_of_range, m, v, o);
    end
  endtask

  // one frame of p reference cycles starting with a rising edge
  task automatic frame(int p);
    @(negedge clk) lrck = 1'b1;
    repeat (p / 2) @(negedge clk);
    lrck = 1'b0;
    repeat (p - p / 2 - 1) @(negedge clk);
  endtask

  function automatic int cls_of(int p);
    if (p >= REF_HZ / 54000  && p <= REF_HZ / 30000)  return 0;
    if (p >= REF_HZ / 108000 && p <= REF_HZ / 60000)  return 1;
    if (p >= REF_HZ / 216000 && p <= REF_HZ / 120000) return 2;
    return -1;
  endfunction

  initial begin
    #(200_000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [1:0] last_mode;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset", 2'd0, 1'b0, 1'b0);

    // R2: first edge only arms; 4 edges give 3 periods
    repeat (4) frame(50);
    check("R2 first edge not counted", 2'd0, 1'b0, 1'b0);
    frame(50);
    check("R2 fourth period confirms", 2'd0, 1'b1, 1'b0);

    // sweep of every period across and beyond all bands (R3 R4 R5 R6)
    last_mode = 2'd0;
    for (int p = 8; p <= 80; p++) begin
      int c;
      repeat (8) frame(p);
      c = cls_of(p);
      if (c < 0)
        check("R6 sweep out of band", last_mode, 1'b0, 1'b1);
      else begin
        last_mode = 2'(c);
        if (c == 0)      check("R3 sweep single", 2'd0, 1'b1, 1'b0);
        else if (c == 1) check("R4 sweep double", 2'd1, 1'b1, 1'b0);
        else             check("R5 sweep quad",   2'd2, 1'b1, 1'b0);
      end
    end

    // R7: debounce count and restart
    repeat (8) frame(14);
    check("R5 quad set", 2'd2, 1'b1, 1'b0);
    repeat (4) frame(50);
    check("R7 three periods hold", 2'd2, 1'b1, 1'b0);
    frame(50);
    check("R7 fourth period switches", 2'd0, 1'b1, 1'b0);
    frame(30); frame(30); frame(30); frame(14);
    frame(30); frame(30); frame(30); frame(30);
    check("R7 interrupted run holds", 2'd0, 1'b1, 1'b0);
    frame(30);
    check("R7 run completes", 2'd1, 1'b1, 1'b0);

    // R8: forced modes
    fm_sel = 2'd3;
    repeat (2) @(negedge clk);
    check("R8 force quad", 2'd2, 1'b1, 1'b0);
    fm_sel = 2'd1;
    repeat (2) @(negedge clk);
    check("R8 force single", 2'd0, 1'b1, 1'b0);
    fm_sel = 2'd2;
    repeat (TIMEOUT + 20) @(negedge clk);
    check("R8 force double through silence", 2'd1, 1'b1, 1'b0);
    fm_sel = 2'd3;
    repeat (3) frame(9);
    check("R8 force quad with bad frames", 2'd2, 1'b1, 1'b0);

    // R9: back to automatic
    fm_sel = 2'd0;
    repeat (2) @(negedge clk);
    check("R9 valid drops on return", 2'd2, 1'b0, 1'b0);
    repeat (4) frame(30);
    check("R9 held before debounce", 2'd2, 1'b0, 1'b0);
    frame(30);
    check("R9 detection resumes", 2'd1, 1'b1, 1'b0);

    // R10: timeout
    repeat (TIMEOUT + 20) @(negedge clk);
    check("R10 timeout clears valid", 2'd1, 1'b0, 1'b0);
    repeat (4) frame(60);
    check("R10 R2 rearm after timeout", 2'd1, 1'b0, 1'b0);
    frame(60);
    check("R10 recovery", 2'd0, 1'b1, 1'b0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule